// File: doc/BRIEF.md
# Span-Scaled PWM Duty Generator

This block takes raw acquisition counts and turns each one into an 8-bit duty code placed between two learned endpoint counts. It then drives one fixed-frequency PWM line with that code. The raw count falls as the sensed capacitance rises, so the lower endpoint (duty code 0) holds the larger count and the upper endpoint (duty code 255) holds the smaller one. Each sample inside the span is scaled by a short restoring divider. The result waits in a pending register and is moved into the PWM compare register only when a PWM period ends.

A calibration sequencer beside the block raises `cal_hold` while it learns new endpoints. While the hold is high, the visible duty stays where it was and the block takes no new samples. After reset the block stays idle for a start-up interval. Samples that arrive during that interval are dropped and the line stays low. An endpoint pair that is equal or inverted produces duty 0 and raises `span_bad`.

Top module: `span_pwm_gen`

## Requirements
- R1: After reset `pwm_out` and `span_bad` are 0 and the duty code is 0.
- R2: Samples strobed during the first STARTUP_CYC clock cycles after reset are ignored. `pwm_out` stays low until a later sample is accepted.
- R3: For `hi_count < smp_count < lo_count`, the duty code is floor(255 × (lo_count − smp_count) / (lo_count − hi_count)).
- R4: A count at or above `lo_count` gives duty code 0.
- R5: A count at or below `hi_count` gives duty code 255, which is a high time of 255/256 of the period.
- R6: If `lo_count <= hi_count` when a sample is accepted, the duty code becomes 0 and `span_bad` goes to 1. The next sample accepted with a valid span clears `span_bad` to 0.
- R7: The PWM period is 256 × STEP_DIV clock cycles. The line is high for duty × STEP_DIV cycles of each period.
- R8: A new duty code takes effect only at a PWM period boundary, so every high pulse has the length of either the old code or the new code.
- R9: While `cal_hold` is 1, samples are ignored and the duty code does not change. After the hold falls, the duty changes only when a new sample is accepted.
- R10: A conversion takes 9 cycles. A strobe that arrives while a conversion is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe: a new raw count is present |
| smp_count | input | CNT_W | Raw acquisition count |
| lo_count | input | CNT_W | Endpoint count for duty code 0 (larger count) |
| hi_count | input | CNT_W | Endpoint count for duty code 255 (smaller count) |
| cal_hold | input | 1 | Calibration in progress: freeze the duty and ignore samples |
| pwm_out | output | 1 | PWM line |
| span_bad | output | 1 | The last accepted sample met an equal or inverted span |

## Verification
Random spans and counts are drawn around and inside the span, so the divider path, both clamps and the nearby edge codes (0, 254 and values near 255) are all exercised. Each result is compared with a floor-division model. Directed patterns cover four cases:
- A strobe during start-up, which separates ignoring the sample from converting it.
- A back-to-back strobe pair, which shows whether a busy conversion is overwritten.
- Equal and inverted spans.
- A hold window.

In the hold test a sample sent during the hold, and the quiet time after the hold falls, must both leave the duty unchanged. A duty change in the middle of a run of pulses is checked by pulse length: a load in the middle of a period would produce a pulse that matches neither the old code nor the new one.

// File: rtl/span_pwm_gen.sv
module span_pwm_gen #(
  parameter int CNT_W       = 16,
  parameter int STEP_DIV    = 4,
  parameter int STARTUP_CYC = 30_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [CNT_W-1:0] smp_count,
  input  logic [CNT_W-1:0] lo_count,
  input  logic [CNT_W-1:0] hi_count,
  input  logic             cal_hold,
  output logic             pwm_out,
  output logic             span_bad
);
  localparam int NW    = CNT_W + 8;
  localparam int ST_W  = $clog2(STARTUP_CYC + 1);
  localparam int PRE_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  // start-up interval
  logic [ST_W-1:0] st_cnt;
  logic            ready;
  assign ready = (st_cnt == ST_W'(STARTUP_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n)      st_cnt <= '0;
    else if (!ready) st_cnt <= st_cnt + 1'b1;
  end

  // sample intake and range decisions
  logic             busy;
  logic             go, span_ok, at_lo, at_hi, start_div;
  logic [CNT_W-1:0] diff;
  logic [NW-1:0]    num;

  assign go        = smp_valid && ready && !busy && !cal_hold;
  assign span_ok   = lo_count > hi_count;
  assign at_lo     = smp_count >= lo_count;
  assign at_hi     = smp_count <= hi_count;
  assign diff      = lo_count - smp_count;
  assign num       = ({8'd0, diff} << 8) - {8'd0, diff};
  assign start_div = go && span_ok && !at_lo && !at_hi;

  // restoring divider, one quotient bit per cycle
  logic [NW-1:0]    rem, den_sh;
  logic [CNT_W-1:0] den;
  logic [2:0]       k;
  logic [7:0]       q, q_nxt;
  logic             ge;

  assign den_sh = {8'd0, den} << k;
  assign ge     = rem >= den_sh;
  assign q_nxt  = q | (ge ? (8'd1 << k) : 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rem  <= '0;
      den  <= '0;
      k    <= '0;
      q    <= '0;
    end else if (start_div) begin
      busy <= 1'b1;
      rem  <= num;
      den  <= lo_count - hi_count;
      k    <= 3'd7;
      q    <= '0;
    end else if (busy) begin
      if (ge) rem <= rem - den_sh;
      q <= q_nxt;
      k <= k - 3'd1;
      if (k == 3'd0) busy <= 1'b0;
    end
  end

  // result commit
  logic       fin, fin_bad;
  logic [7:0] fin_val;

  always_comb begin
    fin     = 1'b0;
    fin_bad = 1'b0;
    fin_val = 8'd0;
    if (busy && k == 3'd0) begin
      fin     = 1'b1;
      fin_val = q_nxt;
    end else if (go && !span_ok) begin
      fin     = 1'b1;
      fin_bad = 1'b1;
    end else if (go && at_lo) begin
      fin     = 1'b1;
    end else if (go && at_hi) begin
      fin     = 1'b1;
      fin_val = 8'd255;
    end
  end

  // PWM counter
  logic [PRE_W-1:0] pre;
  logic [7:0]       phase;
  logic             pre_last, boundary;

  assign pre_last = (pre == PRE_W'(STEP_DIV - 1));
  assign boundary = pre_last && (phase == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      phase <= '0;
    end else if (pre_last) begin
      pre   <= '0;
      phase <= phase + 8'd1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // pending and live duty
  logic [7:0] pend_duty, duty_cur;
  logic       pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_duty <= '0;
      pend_v    <= 1'b0;
      span_bad  <= 1'b0;
      duty_cur  <= '0;
    end else begin
      if (fin) begin
        pend_duty <= fin_val;
        span_bad  <= fin_bad;
      end
      if (cal_hold)                 pend_v <= 1'b0;
      else if (fin)                 pend_v <= 1'b1;
      else if (boundary && pend_v)  pend_v <= 1'b0;
      if (boundary && pend_v && !cal_hold) duty_cur <= pend_duty;
    end
  end

  assign pwm_out = phase < duty_cur;

  // R2
  warmup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!busy && !pend_v));

  // R6
  bad_span_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    span_bad |-> (pend_duty == 8'd0));

  // R7
  pwm_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_cur == 8'd0) |-> !pwm_out);

  // R8
  duty_load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_cur) |-> (phase == 8'd0 && pre == '0));

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_hold |=> $stable(duty_cur));

  // R10
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_div |=> (busy && k == 3'd7));
endmodule

// File: tb/test_span_pwm_gen.sv
module test_span_pwm_gen;
  localparam int CW  = 16;
  localparam int SD  = 2;
  localparam int STC = 300;
  localparam int PER = 256 * SD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [CW-1:0] smp_count = '0;
  logic [CW-1:0] lo_count = '0;
  logic [CW-1:0] hi_count = '0;
  logic          cal_hold = 1'b0;
  logic          pwm_out, span_bad;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  span_pwm_gen #(.CNT_W(CW), .STEP_DIV(SD), .STARTUP_CYC(STC)) i_span_pwm_gen (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_count(smp_count),
    .lo_count(lo_count), .hi_count(hi_count), .cal_hold(cal_hold),
    .pwm_out(pwm_out), .span_bad(span_bad));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc >= 190000);
    failures = failures + 1;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int exp_duty(input int lo, input int hi, input int c);
    if (lo <= hi) return 0;
    if (c >= lo)  return 0;
    if (c <= hi)  return 255;
    return (255 * (lo - c)) / (lo - hi);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(input int c);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_count = CW'(c);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic measure(output int hi_cycles);
    repeat (3 * PER) @(negedge clk);
    hi_cycles = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (pwm_out) hi_cycles = hi_cycles + 1;
    end
  endtask

  task automatic conv_check(input int c, input string tag);
    int h, e;
    send(c);
    measure(h);
    e = exp_duty(int'(lo_count), int'(hi_count), c) * SD;
    check(h == e, tag, h, e);
  endtask

  initial begin
    int h, e, lo, hi, c, prev, run, seen_b, odd_run;
    void'($urandom(32'd5151));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0, "R1 pwm after reset", int'(pwm_out), 0);
    check(span_bad == 1'b0, "R1 span_bad after reset", int'(span_bad), 0);

    lo_count = 16'd5000;
    hi_count = 16'd1000;
    send(1000);
    measure(h);
    check(h == 0, "R2 sample during start-up ignored", h, 0);

    conv_check(1000, "R5 count equal upper endpoint");
    conv_check(500,  "R5 count beyond upper endpoint");
    conv_check(5000, "R4 count equal lower endpoint");
    conv_check(6000, "R4 count beyond lower endpoint");
    conv_check(3000, "R7 mid span high time");
    conv_check(4999, "R3 just inside lower end");
    conv_check(1001, "R3 just inside upper end");

    // R10 back-to-back strobes: second ignored
    @(negedge clk);
    smp_valid = 1'b1; smp_count = 16'd3000;
    @(negedge clk);
    smp_count = 16'd1000;
    @(negedge clk);
    smp_valid = 1'b0;
    measure(h);
    e = exp_duty(5000, 1000, 3000) * SD;
    check(h == e, "R10 strobe during conversion ignored", h, e);

    // R6 invalid spans
    lo_count = 16'd2000; hi_count = 16'd2000;
    conv_check(1500, "R6 equal span gives zero");
    check(span_bad == 1'b1, "R6 span_bad on equal span", int'(span_bad), 1);
    lo_count = 16'd1000; hi_count = 16'd2000;
    conv_check(1000, "R6 inverted span gives zero");
    check(span_bad == 1'b1, "R6 span_bad on inverted span", int'(span_bad), 1);
    lo_count = 16'd5000; hi_count = 16'd1000;
    conv_check(1800, "R6 valid span after bad");
    check(span_bad == 1'b0, "R6 span_bad cleared", int'(span_bad), 0);

    // R8 pulse lengths across a duty change
    send(1800);
    repeat (3 * PER) @(negedge clk);
    send(4200);
    prev = int'(pwm_out);
    for (int i = 0; i < 2 * PER; i++) begin
      @(negedge clk);
      if (prev == 1 && !pwm_out) break;
      prev = int'(pwm_out);
    end
    run = 0; seen_b = 0; odd_run = -1; prev = 0;
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      if (pwm_out) run = run + 1;
      else begin
        if (prev == 1) begin
          if (run == exp_duty(5000, 1000, 4200) * SD) seen_b = 1;
          else if (run != exp_duty(5000, 1000, 1800) * SD) odd_run = run;
        end
        run = 0;
      end
      prev = int'(pwm_out);
    end
    check(odd_run == -1, "R8 no mixed pulse at duty change", odd_run, -1);
    check(seen_b == 1, "R8 new duty reached", seen_b, 1);

    // R9 calibration hold
    conv_check(3000, "R9 duty before hold");
    cal_hold = 1'b1;
    send(1000);
    measure(h);
    e = exp_duty(5000, 1000, 3000) * SD;
    check(h == e, "R9 duty frozen during hold", h, e);
    cal_hold = 1'b0;
    measure(h);
    check(h == e, "R9 duty unchanged after hold without sample", h, e);
    conv_check(1000, "R9 new sample after hold");

    // R3 random spans and counts
    for (int n = 0; n < 25; n++) begin
      hi = 100 + int'($urandom_range(0, 30000));
      lo = hi + 1 + int'($urandom_range(0, 30000));
      c  = hi - 300 + int'($urandom_range(0, lo - hi + 600));
      lo_count = CW'(lo);
      hi_count = CW'(hi);
      conv_check(c, "R3 random sample");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule